// File: doc/BRIEF.md
# Address-Decoded NAND Pin Bridge

This block is a memory-mapped bus slave that lets a processor drive a raw NAND flash device with ordinary byte loads and stores. There are no command or address registers. A store into the NAND window runs one timed write-enable pulse. A load runs one timed read-enable pulse. Low address bits of the access select which flash control lines are active for that access. A store at an offset carrying the CLE and chip-select bits sends a command byte. The ALE and chip-select bits send an address byte. Chip select alone moves data.

A small register space sits beside the window. It holds a read-only status word, which reports flash ready/busy and a sticky transfer-complete flag, and a control word. The control word sets NAND mode, chip enable, pad polarities and chip-select routing. A store is accepted at once, so software polls the complete flag after each command or address byte. Loads and any NAND access that arrives during a transfer are held off with the ready handshake.

Top module: `nandPinBridge`

## Requirements
- R1: In the NAND window (busAddr[8]=0), address bit 2 asserts ALE, bit 3 asserts CLE, bit 4 asserts chip select, bit 5 asserts spare enable and bit 6 asserts write protect. These lines hold from the start of setup until the end of hold. All of them are inactive at idle and during recovery.
- R2: When the sequencer is idle, a window store is accepted in its request cycle (busReady=1), and the strobe sequence runs afterward.
- R3: One unit is 4 clocks. A transfer spends 1 unit in setup, 2 units with the strobe low, 1 unit in hold and 1 unit in recovery. A store therefore occupies the sequencer for 20 clocks after acceptance, and its strobe falls after 4 clocks of setup.
- R4: nandWeN and nandReN are active low and are never low together. ALE and CLE do not change on the clock where either strobe falls.
- R5: Status bit 3 (complete) is 0 after reset. It clears when a NAND transfer starts and sets when recovery ends.
- R6: Status bit 0 reports ready. The source pin is nandRdy[0], or nandRdy[1] when control bit 8 is set. The value is inverted when control bit 7 is set.
- R7: A window load returns, in bits 7:0, the data bus value sampled on the last read-enable-low clock. The bus is stalled until recovery has ended.
- R8: A window access that arrives while a transfer is in progress is stalled until the sequencer is idle.
- R9: If control bit 0 (NAND mode) or bit 20 (chip enable) is 0, a window access is accepted at once. It produces no strobe, leaves the complete flag unchanged, and a load returns 0.
- R10: Control bits 4, 5 and 6 make the chip-select, spare and write-protect pads active low. Control bit 10 routes chip select to nandCsPad[1] instead of nandCsPad[0]. An unused pad sits at its inactive level.
- R11: Register space is busAddr[8]=1. Offset 0 is status, which is read-only. Offset 4 is control, which resets to 0 and reads back as written.
- R12: During a store, nandDataOe is 1 and nandDataOut carries the stored byte from setup through hold. A 0xFF command byte is handled like any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Access request, held until busReady |
| busWe | input | 1 | 1 = store, 0 = load |
| busAddr | input | 9 | Byte address; bit 8 selects register space |
| busWdata | input | 32 | Store data |
| busRdata | output | 32 | Load data, valid with busReady |
| busReady | output | 1 | Access completes on this clock |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandCsPad | output | 2 | Chip-select pads |
| nandSparePad | output | 1 | Spare-area enable pad |
| nandWpPad | output | 1 | Write-protect pad |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandDataOut | output | 8 | Flash data bus, outbound |
| nandDataOe | output | 1 | Outbound data drive enable |
| nandDataIn | input | 8 | Flash data bus, inbound |
| nandRdy | input | 2 | Ready/busy inputs |

## Verification
Stores go out under each pin pattern: command (including 0xFF), address, plain data, and chip select combined with spare and write protect. Each one checks that the address bits map to the right pads and that the driven byte is correct. Back-to-back stores check the stall length against the full 20-clock sequence. A load with a distinct bus value checks both the read strobe and the sampled byte. The same pin pattern is repeated under inverted polarities and routed chip select, which shows whether the control bits act on the pads. Accesses with the block deselected show whether a transfer can leak through when disabled.

// File: rtl/nandBridgePkg.sv
package nandBridgePkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_RECOV,
    PH_RDRET
  } phase_e;

  typedef struct packed {
    logic start;
    logic pinsOn;
    logic driveData;
    logic weLow;
    logic reLow;
    logic sample;
    logic done;
  } seqStrobe_t;

  localparam int NUM_CS        = 2;
  localparam int STAT_RDY_BIT  = 0;
  localparam int STAT_DONE_BIT = 3;
  localparam int CTL_MODE_BIT  = 0;
  localparam int CTL_CSPOL_BIT = 4;
  localparam int CTL_SEPOL_BIT = 5;
  localparam int CTL_WPPOL_BIT = 6;
  localparam int CTL_RBPOL_BIT = 7;
  localparam int CTL_RBSEL_BIT = 8;
  localparam int CTL_CSSEL_BIT = 10;
  localparam int CTL_CE_BIT    = 20;

endpackage

// File: rtl/nandSeqCtrl.sv
module nandSeqCtrl
  import nandBridgePkg::*;
#(
  parameter int CLK_MULT    = 4,
  parameter int SETUP_UNITS = 1,
  parameter int WR_UNITS    = 2,
  parameter int RD_UNITS    = 2,
  parameter int HOLD_UNITS  = 1,
  parameter int REC_UNITS   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       busWe,
  input  logic       winHit,
  input  logic       accessOk,
  output logic       busReady,
  output seqStrobe_t stb
);

  localparam int SETUP_CYC = SETUP_UNITS * CLK_MULT;
  localparam int WR_CYC    = WR_UNITS * CLK_MULT;
  localparam int RD_CYC    = RD_UNITS * CLK_MULT;
  localparam int HOLD_CYC  = HOLD_UNITS * CLK_MULT;
  localparam int REC_CYC   = REC_UNITS * CLK_MULT;
  localparam int MAX_A     = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_B     = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC   = (MAX_C > REC_CYC) ? MAX_C : REC_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             isRead;
  logic             lastTick;
  logic             nandAccess;

  assign lastTick   = (cnt == '0);
  assign nandAccess = busReq && winHit && accessOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      isRead <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (nandAccess) begin
            phase  <= PH_SETUP;
            cnt    <= CNT_W'(SETUP_CYC - 1);
            isRead <= !busWe;
          end
        end
        PH_SETUP: begin
          if (lastTick) begin
            phase <= PH_PULSE;
            cnt   <= isRead ? CNT_W'(RD_CYC - 1) : CNT_W'(WR_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_PULSE: begin
          if (lastTick) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (lastTick) begin
            phase <= PH_RECOV;
            cnt   <= CNT_W'(REC_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOV: begin
          if (lastTick) begin
            phase <= isRead ? PH_RDRET : PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.start     = nandAccess && (phase == PH_IDLE);
    stb.pinsOn    = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
    stb.driveData = stb.pinsOn && !isRead;
    stb.weLow     = (phase == PH_PULSE) && !isRead;
    stb.reLow     = (phase == PH_PULSE) && isRead;
    stb.sample    = (phase == PH_PULSE) && isRead && lastTick;
    stb.done      = (phase == PH_RECOV) && lastTick;
  end

  always_comb begin
    if (!winHit || !accessOk) busReady = 1'b1;
    else if (busWe)           busReady = (phase == PH_IDLE);
    else                      busReady = (phase == PH_RDRET);
  end

  // pulse-length checker counter
  logic [CNT_W:0] pulseSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pulseSeen <= '0;
    else if (phase == PH_PULSE)  pulseSeen <= pulseSeen + 1'b1;
    else                         pulseSeen <= '0;
  end

  // R2
  accept_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busReady && winHit && accessOk && busWe) |=> (phase == PH_SETUP));

  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase != PH_IDLE) && (phase != PH_RDRET) && nandAccess) |-> !busReady);

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phase == PH_PULSE) |-> (pulseSeen == (isRead ? (CNT_W+1)'(RD_CYC) : (CNT_W+1)'(WR_CYC))));

endmodule

// File: rtl/nandPinDatapath.sv
module nandPinDatapath
  import nandBridgePkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  seqStrobe_t        stb,
  output logic              winHit,
  output logic              accessOk,
  output logic              nandCle,
  output logic              nandAle,
  output logic [NUM_CS-1:0] nandCsPad,
  output logic              nandSparePad,
  output logic              nandWpPad,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [BYTE_W-1:0] nandDataOut,
  output logic              nandDataOe,
  input  logic [BYTE_W-1:0] nandDataIn,
  input  logic [NUM_CS-1:0] nandRdy
);

  localparam int PIN_LO = 2;
  localparam int PIN_N  = 5;

  logic              regHit;
  logic [DATA_W-1:0] ctrlReg;
  logic [PIN_N-1:0]  pinPat;
  logic [BYTE_W-1:0] outByte;
  logic [BYTE_W-1:0] inByte;
  logic              doneBit;
  logic              rdyTrue;
  logic              csAct;
  logic [DATA_W-1:0] statusWord;
  logic              unusedAddrBits;

  assign regHit         = busAddr[ADDR_W-1];
  assign winHit         = !regHit;
  assign accessOk       = ctrlReg[CTL_MODE_BIT] && ctrlReg[CTL_CE_BIT];
  assign unusedAddrBits = ^{busAddr[1:0], busAddr[ADDR_W-2:PIN_LO+PIN_N]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    ctrlReg <= '0;
    else if (busReq && busWe && regHit && busAddr[2]) ctrlReg <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPat  <= '0;
      outByte <= '0;
    end else if (stb.start) begin
      pinPat  <= busAddr[PIN_LO+PIN_N-1:PIN_LO];
      outByte <= busWdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           inByte <= '0;
    else if (stb.sample) inByte <= nandDataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          doneBit <= 1'b0;
    else if (stb.start) doneBit <= 1'b0;
    else if (stb.done)  doneBit <= 1'b1;
  end

  assign rdyTrue = nandRdy[ctrlReg[CTL_RBSEL_BIT]] ^ ctrlReg[CTL_RBPOL_BIT];

  always_comb begin
    statusWord                = '0;
    statusWord[STAT_RDY_BIT]  = rdyTrue;
    statusWord[STAT_DONE_BIT] = doneBit;
  end

  always_comb begin
    if (regHit)        busRdata = busAddr[2] ? ctrlReg : statusWord;
    else if (accessOk) busRdata = DATA_W'(inByte);
    else               busRdata = '0;
  end

  assign nandAle      = stb.pinsOn && pinPat[0];
  assign nandCle      = stb.pinsOn && pinPat[1];
  assign csAct        = stb.pinsOn && pinPat[2];
  assign nandSparePad = (stb.pinsOn && pinPat[3]) ^ ctrlReg[CTL_SEPOL_BIT];
  assign nandWpPad    = (stb.pinsOn && pinPat[4]) ^ ctrlReg[CTL_WPPOL_BIT];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csPad
    assign nandCsPad[i] = (csAct && (ctrlReg[CTL_CSSEL_BIT] == 1'(i))) ^ ctrlReg[CTL_CSPOL_BIT];
  end

  assign nandWeN     = !stb.weLow;
  assign nandReN     = !stb.reLow;
  assign nandDataOut = outByte;
  assign nandDataOe  = stb.driveData;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R4
  latch_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) || $fell(nandReN)) |-> ($stable(nandCle) && $stable(nandAle)));

  // R5
  done_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !doneBit);

  // R12
  data_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDataOe);

endmodule

// File: rtl/nandPinBridge.sv
module nandPinBridge
  import nandBridgePkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int CLK_MULT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              nandCle,
  output logic              nandAle,
  output logic [1:0]        nandCsPad,
  output logic              nandSparePad,
  output logic              nandWpPad,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [BYTE_W-1:0] nandDataOut,
  output logic              nandDataOe,
  input  logic [BYTE_W-1:0] nandDataIn,
  input  logic [1:0]        nandRdy
);

  seqStrobe_t stb;
  logic       winHit;
  logic       accessOk;

  nandSeqCtrl #(
    .CLK_MULT(CLK_MULT)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busReq  (busReq),
    .busWe   (busWe),
    .winHit  (winHit),
    .accessOk(accessOk),
    .busReady(busReady),
    .stb     (stb)
  );

  nandPinDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .busReq      (busReq),
    .busWe       (busWe),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .stb         (stb),
    .winHit      (winHit),
    .accessOk    (accessOk),
    .nandCle     (nandCle),
    .nandAle     (nandAle),
    .nandCsPad   (nandCsPad),
    .nandSparePad(nandSparePad),
    .nandWpPad   (nandWpPad),
    .nandWeN     (nandWeN),
    .nandReN     (nandReN),
    .nandDataOut (nandDataOut),
    .nandDataOe  (nandDataOe),
    .nandDataIn  (nandDataIn),
    .nandRdy     (nandRdy)
  );

endmodule

// File: tb/nandPinBridge_tb.sv
`timescale 1ns/100ps
module nandPinBridge_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic        busWe = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        nandCle, nandAle, nandSparePad, nandWpPad, nandWeN, nandReN, nandDataOe;
  logic [1:0]  nandCsPad;
  logic [7:0]  nandDataOut;
  logic [7:0]  nandDataIn = '0;
  logic [1:0]  nandRdy = 2'b01;

  int vecs = 0;
  int bad  = 0;

  always #2.5 clk = ~clk;

  nandPinBridge dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .nandCle(nandCle), .nandAle(nandAle), .nandCsPad(nandCsPad),
    .nandSparePad(nandSparePad), .nandWpPad(nandWpPad), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDataOut(nandDataOut), .nandDataOe(nandDataOe),
    .nandDataIn(nandDataIn), .nandRdy(nandRdy)
  );

  typedef struct packed {
    logic       isRd;
    logic       cle;
    logic       ale;
    logic [1:0] cs;
    logic       se;
    logic       wp;
    logic [7:0] data;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] ctlShadow = '0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t mkExp(input logic isRd, input logic [8:0] a, input logic [7:0] d);
    exp_t e;
    logic p;
    p      = ctlShadow[4];
    e.isRd = isRd;
    e.ale  = a[2];
    e.cle  = a[3];
    e.cs[0] = ((ctlShadow[10] == 1'b0) && a[4]) ^ p;
    e.cs[1] = ((ctlShadow[10] == 1'b1) && a[4]) ^ p;
    e.se   = a[5] ^ ctlShadow[5];
    e.wp   = a[6] ^ ctlShadow[6];
    e.data = d;
    return e;
  endfunction

  task automatic busXfer(input logic we, input logic [8:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int stalls);
    stalls = 0;
    @(negedge clk);
    busReq = 1'b1; busWe = we; busAddr = a; busWdata = wd;
    #1;
    while (!busReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    rd = busRdata;
    @(posedge clk);
    #1 busReq = 1'b0;
  endtask

  task automatic ctlWrite(input logic [31:0] v);
    logic [31:0] rd;
    int s;
    busXfer(1'b1, 9'h104, v, rd, s);
    ctlShadow = v;
  endtask

  task automatic statusRead(output logic [31:0] v);
    int s;
    busXfer(1'b0, 9'h100, 32'h0, v, s);
  endtask

  // monitor: pops expected strobes and compares pads
  logic prevWe = 1'b1, prevRe = 1'b1, prevCle = 1'b0, prevAle = 1'b0;
  int   lowCnt = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rstN) begin
      if ((!nandWeN && prevWe) || (!nandReN && prevRe)) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected strobe", {nandWeN, nandReN}, 2'b11);
        end else begin
          cur = expQ.pop_front();
          check(cur.isRd == !nandReN, "R4 strobe kind", !nandReN, cur.isRd);
          check(nandCle == cur.cle && nandAle == cur.ale, "R1 cle/ale", {nandCle, nandAle}, {cur.cle, cur.ale});
          check(nandCsPad == cur.cs, "R10 cs pads", nandCsPad, cur.cs);
          check(nandSparePad == cur.se && nandWpPad == cur.wp, "R1 se/wp", {nandSparePad, nandWpPad}, {cur.se, cur.wp});
          check(prevCle == nandCle && prevAle == nandAle, "R4 setup", {prevCle, prevAle}, {nandCle, nandAle});
          if (!cur.isRd)
            check(nandDataOe && nandDataOut == cur.data, "R12 data out", {nandDataOe, nandDataOut}, {1'b1, cur.data});
        end
        lowCnt = 1;
      end else if (!nandWeN || !nandReN) begin
        lowCnt++;
      end else if ((nandWeN && !prevWe) || (nandReN && !prevRe)) begin
        check(lowCnt == 8, "R3 strobe width", lowCnt, 8);
      end
      check(!(!nandWeN && !nandReN), "R4 exclusive", {nandWeN, nandReN}, 2'b11);
    end
    prevWe = nandWeN; prevRe = nandReN; prevCle = nandCle; prevAle = nandAle;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int s;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // reset state
    check(nandWeN && nandReN, "R4 reset strobes", {nandWeN, nandReN}, 2'b11);
    check(nandCsPad == 2'b00 && !nandCle && !nandAle, "R1 reset pins", {nandCsPad, nandCle, nandAle}, 0);
    statusRead(rd);
    check(rd[3] == 1'b0, "R5 done after reset", rd[3], 0);
    check(rd[0] == 1'b1, "R6 ready pin0", rd[0], 1);
    busXfer(1'b0, 9'h104, 0, rd, s);
    check(rd == 32'h0, "R11 control reset", rd, 0);

    // deselected: ignored
    busXfer(1'b1, 9'h018, 32'hFF, rd, s);
    check(s == 0, "R9 ignored store stalls", s, 0);
    busXfer(1'b0, 9'h010, 0, rd, s);
    check(rd == 0 && s == 0, "R9 ignored load", rd, 0);
    repeat (25) @(negedge clk);
    statusRead(rd);
    check(rd[3] == 1'b0, "R9 done unchanged", rd[3], 0);

    // select: mode then chip enable
    ctlWrite(32'h0000_0001);
    ctlWrite(32'h0010_0001);
    busXfer(1'b0, 9'h104, 0, rd, s);
    check(rd == 32'h0010_0001, "R11 control readback", rd, 32'h0010_0001);

    // reset command 0xFF with CS|CLE
    expQ.push_back(mkExp(1'b0, 9'h018, 8'hFF));
    busXfer(1'b1, 9'h018, 32'hFF, rd, s);
    check(s == 0, "R2 store accepted at once", s, 0);
    n = 0;
    @(negedge clk);
    while (nandWeN) begin n++; @(negedge clk); end
    check(n == 4, "R3 setup length", n, 4);
    statusRead(rd);
    check(rd[3] == 1'b0, "R5 done cleared at start", rd[3], 0);
    repeat (20) @(negedge clk);
    statusRead(rd);
    check(rd[3] == 1'b1, "R5 done after recovery", rd[3], 1);

    // address byte then data byte back to back
    expQ.push_back(mkExp(1'b0, 9'h014, 8'h3A));
    expQ.push_back(mkExp(1'b0, 9'h010, 8'h5C));
    busXfer(1'b1, 9'h014, 32'h3A, rd, s);
    busXfer(1'b1, 9'h010, 32'h5C, rd, s);
    check(s == 20, "R8 stall while busy", s, 20);

    // data load
    nandDataIn = 8'hA7;
    expQ.push_back(mkExp(1'b1, 9'h010, 8'h00));
    busXfer(1'b0, 9'h010, 0, rd, s);
    check(rd == 32'h0000_00A7, "R7 load data", rd, 32'hA7);
    check(s >= 20, "R7 load stalled", s, 20);
    statusRead(rd);
    check(rd[3] == 1'b1, "R5 done after load", rd[3], 1);

    // inverted polarities and routed chip select
    ctlWrite(32'h0010_0471);
    #1;
    check(nandCsPad == 2'b11 && nandSparePad && nandWpPad, "R10 idle pads inverted",
          {nandCsPad, nandSparePad, nandWpPad}, 4'hF);
    expQ.push_back(mkExp(1'b0, 9'h070, 8'h11));
    busXfer(1'b1, 9'h070, 32'h11, rd, s);
    repeat (25) @(negedge clk);
    check(nandCsPad == 2'b11 && nandSparePad && nandWpPad, "R10 pads after access",
          {nandCsPad, nandSparePad, nandWpPad}, 4'hF);

    // ready routing and polarity
    ctlWrite(32'h0010_0001);
    nandRdy = 2'b01;
    statusRead(rd);
    check(rd[0] == 1'b1, "R6 ready pin0", rd[0], 1);
    ctlWrite(32'h0010_0101);
    statusRead(rd);
    check(rd[0] == 1'b0, "R6 ready routed pin1", rd[0], 0);
    ctlWrite(32'h0010_0181);
    statusRead(rd);
    check(rd[0] == 1'b1, "R6 ready inverted", rd[0], 1);
    busXfer(1'b1, 9'h100, 32'hFFFF_FFFF, rd, s);
    statusRead(rd);
    check(rd[31:4] == 0 && rd[3] == 1'b1, "R11 status read-only", rd, 32'h9);

    // deselect: chip enable off first, then mode
    ctlWrite(32'h0000_0001);
    busXfer(1'b1, 9'h010, 32'h77, rd, s);
    check(s == 0, "R9 chip enable off", s, 0);
    busXfer(1'b0, 9'h010, 0, rd, s);
    check(rd == 0, "R9 load zero", rd, 0);
    ctlWrite(32'h0000_0000);
    repeat (25) @(negedge clk);
    statusRead(rd);
    check(rd[3] == 1'b1, "R9 done kept", rd[3], 1);
    check(expQ.size() == 0, "R1 all strobes seen", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule